// File: doc/BRIEF.md
# Channel-List ADC Acquisition Controller

This block sequences conversions of an external analog-to-digital converter from a short list of channel entries and collects the results in a sample FIFO. Software works through a 16-bit register interface with four word addresses. It loads channel entries, picks a trigger source, and then either starts conversions itself or lets a scan tick or an external trigger line start them. Each entry packs a channel number, a gain code, a polarity bit and a differential-mode bit into one byte. When a conversion is launched, these fields are driven onto the converter's select pins.

Each launch takes the next list entry in order. In continuous mode the list wraps around. Otherwise, triggers that arrive after the last entry are not served. The converter answers with a one-cycle done pulse carrying a 12-bit code. The block stores that code with its top bit inverted, so software recovers the converter code by flipping bit 11 again. A status word reports the FIFO fill levels and the pending interrupt sources. An interrupt line combines the pending sources with a global enable.

Word addresses (busAddr):

- 0: write the trigger configuration word (cfg1); a read is the start address and returns 0.
- 1: write the enable word (cfg2); a read returns the status word.
- 2: a write clears pending interrupts; a read pops a sample.
- 3: a write appends a list entry; a read returns 0.

Top module: `adcq_top`

## Requirements
- R1: After reset the status word reads 0x0004 (sample FIFO empty only), `irq` is low and `convStart` is low.
- R2: Reads of address 0 and address 3 return 0x0000. A read of address 1 returns status. A read of address 2 returns sample data, zero-extended in bits 11:0.
- R3: A list entry carries the channel in bits 3:0, the gain in bits 5:4, unipolar in bit 6 and differential in bit 7. On a launch these appear on `convChan`, `convGain`, `convUnipolar` and `convDiff` in the same cycle as the one-cycle `convStart` pulse, which follows the trigger cycle.
- R4: cfg1 bits 1:0 select the trigger source: 0 off, 1 software, 2 scan tick, 3 external line. In software mode a read of address 0 launches one conversion. In mode 0 nothing launches.
- R5: In mode 2 a `scanTick` pulse launches. In mode 3 an edge on `extTrig` launches: a rising edge when cfg1 bit 3 is 0, a falling edge when it is 1.
- R6: Launches consume list entries in write order. With cfg1 bit 2 clear, a trigger after the last entry is ignored. With bit 2 set, the list restarts at its first entry.
- R7: Status bit 0 is high from a launch until `convDone`. Triggers during that time are ignored.
- R8: On `convDone` while busy, the stored sample is `convData` with bit 11 inverted.
- R9: cfg2 bit 10 enables the sample FIFO and bit 9 enables the channel list. While either bit is clear, that store is emptied and writes to it are lost.
- R10: The status word carries, in order of bit position from low to high: bit 0 busy, bit 1 list full (16 entries), bit 2 sample FIFO empty, bit 3 at least half full (16 samples), and bit 4 full (32 samples). Bit 8 is the half-full pending flag, bit 9 the external pending flag, and bits 12:10 read 0.
- R11: Writes to a full list or a full sample FIFO are dropped. A read of an empty sample FIFO returns the last value popped, or 0 after reset.
- R12: The external pending flag sets on an active trigger edge when cfg1 bit 9 is 1. The half-full pending flag sets when the sample count reaches half when cfg1 bit 8 is 1. `irq` is cfg1 bit 15 AND any pending flag.
- R13: A write to address 2 clears both pending flags. An event in the same cycle still sets its flag.
- R14: A pop and a conversion result in the same cycle both take effect, even when the sample FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register word address |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access; side effects at the clock edge |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from busAddr and state |
| extTrig | input | 1 | External trigger line, synchronous to clk |
| scanTick | input | 1 | Scan-rate tick pulse |
| convDone | input | 1 | Converter result valid pulse |
| convData | input | 12 | Converter result code |
| convStart | output | 1 | One-cycle conversion start pulse |
| convChan | output | 4 | Selected channel |
| convGain | output | 2 | Selected gain code |
| convUnipolar | output | 1 | Unipolar range select |
| convDiff | output | 1 | Differential input select |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions are provoked on purpose.

- **Pop and result in the same cycle.** The bench fills the sample FIFO to 32, starts one more conversion, and then drives a sample read in the same cycle as `convDone`. It judges the outcome by two things: the full flag must stay set, and after a complete drain the last value popped must be the result that arrived during the collision.
- **Interrupt clear and external edge in the same cycle.** A write to address 2 is issued in the same cycle as a rising edge of `extTrig`. The pending bit and `irq` must read as set afterwards.

A behavioural reference model predicts the read data, `irq`, and the start and select outputs on every cycle in between.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  localparam int BUS_W = 16;
  localparam int ENTRY_W = 8;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SOFT = 2'd1,
    MODE_SCAN = 2'd2,
    MODE_EXT  = 2'd3
  } trigMode_t;

  localparam logic [1:0] ADDR_CFG1 = 2'd0;  // write cfg1, read = start
  localparam logic [1:0] ADDR_CFG2 = 2'd1;  // write cfg2, read = status
  localparam logic [1:0] ADDR_DATA = 2'd2;  // write = irq clear, read = pop
  localparam logic [1:0] ADDR_LIST = 2'd3;  // write = list entry

  // cfg1 bit positions
  localparam int C1_IRQ_EN   = 15;
  localparam int C1_EXT_IE   = 9;
  localparam int C1_HALF_IE  = 8;
  localparam int C1_FALLING  = 3;
  localparam int C1_CONT     = 2;
  // cfg2 bit positions
  localparam int C2_SAMP_EN  = 10;
  localparam int C2_LIST_EN  = 9;

  typedef struct packed {
    logic listPush;
    logic listFlush;
    logic listAdvance;
    logic contMode;
    logic samplePush;
    logic samplePop;
    logic sampleFlush;
  } dpStrobe_t;
endpackage

// File: rtl/adcq_datapath.sv
module adcq_datapath
  import adcq_pkg::*;
#(
  parameter int LIST_DEPTH   = 16,
  parameter int SAMPLE_DEPTH = 32,
  parameter int SAMPLE_W     = 12,
  localparam int LIST_AW  = $clog2(LIST_DEPTH),
  localparam int LCW      = LIST_AW + 1,
  localparam int SAMP_AW  = $clog2(SAMPLE_DEPTH),
  localparam int SCW      = SAMP_AW + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [ENTRY_W-1:0]  listWdata,
  input  logic [SAMPLE_W-1:0] sampleWdata,
  output logic [ENTRY_W-1:0]  listEntry,
  output logic                listAvail,
  output logic [LCW-1:0]      listCount,
  output logic [SCW-1:0]      sampleCount,
  output logic [SAMPLE_W-1:0] sampleRead
);
  localparam logic [LCW-1:0] LIST_FULL = LCW'(LIST_DEPTH);
  localparam logic [SCW-1:0] SAMP_FULL = SCW'(SAMPLE_DEPTH);
  localparam logic [SAMP_AW-1:0] SAMP_LAST = SAMP_AW'(SAMPLE_DEPTH - 1);

  // ---------------- channel list (indexed, non-destructive) ----------------
  logic [ENTRY_W-1:0] listMem [LIST_DEPTH];
  logic [LCW-1:0] listCnt, listIdx, effIdx, nextIdx;
  logic listWrOk;

  assign effIdx    = (strobe.contMode && listIdx >= listCnt) ? '0 : listIdx;
  assign nextIdx   = effIdx + 1'b1;
  assign listAvail = effIdx < listCnt;
  assign listEntry = listMem[effIdx[LIST_AW-1:0]];
  assign listWrOk  = strobe.listPush && !strobe.listFlush && (listCnt != LIST_FULL);
  assign listCount = listCnt;

  always_ff @(posedge clk) begin
    if (listWrOk) listMem[listCnt[LIST_AW-1:0]] <= listWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      listCnt <= '0;
      listIdx <= '0;
    end else if (strobe.listFlush) begin
      listCnt <= '0;
      listIdx <= '0;
    end else begin
      if (listWrOk) listCnt <= listCnt + 1'b1;
      if (strobe.listAdvance)
        listIdx <= (strobe.contMode && nextIdx == listCnt) ? '0 : nextIdx;
    end
  end

  // ---------------- sample FIFO ----------------
  logic [SAMPLE_W-1:0] sampMem [SAMPLE_DEPTH];
  logic [SAMP_AW-1:0] wrPtr, rdPtr;
  logic [SCW-1:0] sampCnt;
  logic [SAMPLE_W-1:0] lastVal;
  logic doPop, doPush;

  assign doPop  = strobe.samplePop && (sampCnt != '0);
  assign doPush = strobe.samplePush && !strobe.sampleFlush && ((sampCnt != SAMP_FULL) || doPop);
  assign sampleRead  = (sampCnt != '0) ? sampMem[rdPtr] : lastVal;
  assign sampleCount = sampCnt;

  always_ff @(posedge clk) begin
    if (doPush) sampMem[wrPtr] <= sampleWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastVal <= '0;
    end else if (doPop) begin
      lastVal <= sampMem[rdPtr];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      sampCnt <= '0;
    end else if (strobe.sampleFlush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      sampCnt <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == SAMP_LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == SAMP_LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   sampCnt <= sampCnt + 1'b1;
        2'b01:   sampCnt <= sampCnt - 1'b1;
        default: sampCnt <= sampCnt;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    sampCnt <= SAMP_FULL && listCnt <= LIST_FULL);

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleFlush |=> sampCnt == '0);

  p_list_flush_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.listFlush |=> listCnt == '0);

  p_pushpop_keeps_count_r14: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.samplePush && strobe.samplePop && !strobe.sampleFlush && sampCnt != '0)
      |=> $stable(sampCnt));
endmodule

// File: rtl/adcq_ctrl.sv
module adcq_ctrl
  import adcq_pkg::*;
#(
  parameter int LIST_DEPTH   = 16,
  parameter int SAMPLE_DEPTH = 32,
  parameter int SAMPLE_W     = 12,
  localparam int LCW = $clog2(LIST_DEPTH) + 1,
  localparam int SCW = $clog2(SAMPLE_DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          busAddr,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [BUS_W-1:0]    busWdata,
  output logic [BUS_W-1:0]    busRdata,
  input  logic                extTrig,
  input  logic                scanTick,
  input  logic                convDone,
  input  logic [SAMPLE_W-1:0] convData,
  output logic                convStart,
  output logic [3:0]          convChan,
  output logic [1:0]          convGain,
  output logic                convUnipolar,
  output logic                convDiff,
  output logic                irq,
  output dpStrobe_t           strobe,
  output logic [ENTRY_W-1:0]  listWdata,
  output logic [SAMPLE_W-1:0] sampleWdata,
  input  logic [ENTRY_W-1:0]  listEntry,
  input  logic                listAvail,
  input  logic [LCW-1:0]      listCount,
  input  logic [SCW-1:0]      sampleCount,
  input  logic [SAMPLE_W-1:0] sampleRead
);
  localparam logic [LCW-1:0] LIST_FULL = LCW'(LIST_DEPTH);
  localparam logic [SCW-1:0] SAMP_FULL = SCW'(SAMPLE_DEPTH);
  localparam logic [SCW-1:0] SAMP_HALF = SCW'(SAMPLE_DEPTH / 2);
  localparam logic [SAMPLE_W-1:0] CODE_FLIP = SAMPLE_W'(1) << (SAMPLE_W - 1);

  // configuration bits kept
  logic [1:0] cfgMode;
  logic cfgIrqEn, cfgExtIe, cfgHalfIe, cfgFalling, cfgCont;
  logic cfgSampEn, cfgListEn;

  logic busy, extPrev, prevHalf, pendExt, pendHalf;
  trigMode_t mode;
  logic extEdge, trigReq, launch, doneEv, halfFull;
  logic extSet, halfSet, irqClr;

  assign mode     = trigMode_t'(cfgMode);
  assign extEdge  = cfgFalling ? (extPrev && !extTrig) : (!extPrev && extTrig);
  assign halfFull = sampleCount >= SAMP_HALF;

  always_comb begin
    case (mode)
      MODE_SOFT: trigReq = busRd && (busAddr == ADDR_CFG1);
      MODE_SCAN: trigReq = scanTick;
      MODE_EXT:  trigReq = extEdge;
      default:   trigReq = 1'b0;
    endcase
  end

  assign launch  = trigReq && !busy && listAvail;
  assign doneEv  = busy && convDone;
  assign extSet  = extEdge && cfgExtIe;
  assign halfSet = halfFull && !prevHalf && cfgHalfIe;
  assign irqClr  = busWr && (busAddr == ADDR_DATA);

  always_comb begin
    strobe.listPush    = busWr && (busAddr == ADDR_LIST);
    strobe.listFlush   = !cfgListEn;
    strobe.listAdvance = launch;
    strobe.contMode    = cfgCont;
    strobe.samplePush  = doneEv;
    strobe.samplePop   = busRd && (busAddr == ADDR_DATA) && (sampleCount != '0);
    strobe.sampleFlush = !cfgSampEn;
  end
  assign listWdata   = busWdata[ENTRY_W-1:0];
  assign sampleWdata = convData ^ CODE_FLIP;

  // register read mux
  logic [BUS_W-1:0] statusWord;
  always_comb begin
    statusWord     = '0;
    statusWord[9]  = pendExt;
    statusWord[8]  = pendHalf;
    statusWord[4]  = sampleCount == SAMP_FULL;
    statusWord[3]  = halfFull;
    statusWord[2]  = sampleCount == '0;
    statusWord[1]  = listCount == LIST_FULL;
    statusWord[0]  = busy;
    case (busAddr)
      ADDR_CFG2: busRdata = statusWord;
      ADDR_DATA: busRdata = BUS_W'(sampleRead);
      default:   busRdata = '0;
    endcase
  end

  assign irq = cfgIrqEn && (pendExt || pendHalf);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgMode <= '0; cfgIrqEn <= 1'b0; cfgExtIe <= 1'b0; cfgHalfIe <= 1'b0;
      cfgFalling <= 1'b0; cfgCont <= 1'b0; cfgSampEn <= 1'b0; cfgListEn <= 1'b0;
    end else if (busWr && busAddr == ADDR_CFG1) begin
      cfgMode    <= busWdata[1:0];
      cfgIrqEn   <= busWdata[C1_IRQ_EN];
      cfgExtIe   <= busWdata[C1_EXT_IE];
      cfgHalfIe  <= busWdata[C1_HALF_IE];
      cfgFalling <= busWdata[C1_FALLING];
      cfgCont    <= busWdata[C1_CONT];
    end else if (busWr && busAddr == ADDR_CFG2) begin
      cfgSampEn  <= busWdata[C2_SAMP_EN];
      cfgListEn  <= busWdata[C2_LIST_EN];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; convStart <= 1'b0;
      convChan <= '0; convGain <= '0; convUnipolar <= 1'b0; convDiff <= 1'b0;
      extPrev <= 1'b0; prevHalf <= 1'b0; pendExt <= 1'b0; pendHalf <= 1'b0;
    end else begin
      convStart <= launch;
      if (launch) begin
        busy         <= 1'b1;
        convChan     <= listEntry[3:0];
        convGain     <= listEntry[5:4];
        convUnipolar <= listEntry[6];
        convDiff     <= listEntry[7];
      end else if (doneEv) begin
        busy <= 1'b0;
      end
      extPrev  <= extTrig;
      prevHalf <= halfFull;
      pendExt  <= (irqClr ? 1'b0 : pendExt)  | extSet;
      pendHalf <= (irqClr ? 1'b0 : pendHalf) | halfSet;
    end
  end

  // ---------------- assertions ----------------
  p_start_from_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> !$past(busy));

  p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !convDone) |=> busy);

  p_off_mode_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgMode) == MODE_OFF) |-> !convStart);

  p_irq_clear_r13: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && !extSet && !halfSet) |=> (!pendExt && !pendHalf));

  p_event_survives_clear_r13: assert property (@(posedge clk) disable iff (!rstN)
    extSet |=> pendExt);
endmodule

// File: rtl/adcq_top.sv
module adcq_top
  import adcq_pkg::*;
#(
  parameter int LIST_DEPTH   = 16,
  parameter int SAMPLE_DEPTH = 32,
  parameter int SAMPLE_W     = 12,
  localparam int LCW = $clog2(LIST_DEPTH) + 1,
  localparam int SCW = $clog2(SAMPLE_DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          busAddr,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [15:0]         busWdata,
  output logic [15:0]         busRdata,
  input  logic                extTrig,
  input  logic                scanTick,
  input  logic                convDone,
  input  logic [SAMPLE_W-1:0] convData,
  output logic                convStart,
  output logic [3:0]          convChan,
  output logic [1:0]          convGain,
  output logic                convUnipolar,
  output logic                convDiff,
  output logic                irq
);
  dpStrobe_t           strobe;
  logic [ENTRY_W-1:0]  listWdata, listEntry;
  logic [SAMPLE_W-1:0] sampleWdata, sampleRead;
  logic                listAvail;
  logic [LCW-1:0]      listCount;
  logic [SCW-1:0]      sampleCount;

  adcq_ctrl #(.LIST_DEPTH(LIST_DEPTH), .SAMPLE_DEPTH(SAMPLE_DEPTH), .SAMPLE_W(SAMPLE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata),
    .extTrig(extTrig), .scanTick(scanTick), .convDone(convDone), .convData(convData),
    .convStart(convStart), .convChan(convChan), .convGain(convGain),
    .convUnipolar(convUnipolar), .convDiff(convDiff), .irq(irq),
    .strobe(strobe), .listWdata(listWdata), .sampleWdata(sampleWdata),
    .listEntry(listEntry), .listAvail(listAvail), .listCount(listCount),
    .sampleCount(sampleCount), .sampleRead(sampleRead)
  );

  adcq_datapath #(.LIST_DEPTH(LIST_DEPTH), .SAMPLE_DEPTH(SAMPLE_DEPTH), .SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .listWdata(listWdata), .sampleWdata(sampleWdata),
    .listEntry(listEntry), .listAvail(listAvail), .listCount(listCount),
    .sampleCount(sampleCount), .sampleRead(sampleRead)
  );
endmodule

// File: tb/sim_adcq_top.sv
`timescale 1ns/1ps
module sim_adcq_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic extTrig = 1'b0, scanTick = 1'b0, convDone = 1'b0;
  logic [11:0] convData = '0;
  logic convStart, convUnipolar, convDiff, irq;
  logic [3:0] convChan;
  logic [1:0] convGain;

  always #5 clk = ~clk;

  adcq_top u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .extTrig(extTrig), .scanTick(scanTick),
    .convDone(convDone), .convData(convData), .convStart(convStart), .convChan(convChan),
    .convGain(convGain), .convUnipolar(convUnipolar), .convDiff(convDiff), .irq(irq)
  );

  int checks = 0, errors = 0;
  string curReq = "R1";
  logic extLvl = 1'b0;
  logic [15:0] rdSample;
  logic modelOn = 1'b0;

  // ---------------- behavioural reference model ----------------
  logic [15:0] m1, m2;
  logic [7:0]  listQ[$];
  int          mIdx;
  logic [11:0] sampQ[$];
  logic [11:0] lastS;
  logic mBusy, mStart, mPendExt, mPendHalf, mPrevHalf, mExtPrev;
  logic [7:0] mSel;

  always @(posedge clk) begin : model
    logic edgeM, trig, cont, launch, done, halfNow, extSet, halfSet, clr, pop;
    int eff, oldSize, nxt;
    logic [7:0] ent;
    if (!rstN) begin
      m1 = 0; m2 = 0; listQ.delete(); mIdx = 0; sampQ.delete(); lastS = 0;
      mBusy = 0; mStart = 0; mSel = 0; mPendExt = 0; mPendHalf = 0;
      mPrevHalf = 0; mExtPrev = 0;
    end else begin
      edgeM = m1[3] ? (mExtPrev && !extTrig) : (!mExtPrev && extTrig);
      case (m1[1:0])
        2'd1: trig = busRd && busAddr == 2'd0;
        2'd2: trig = scanTick;
        2'd3: trig = edgeM;
        default: trig = 1'b0;
      endcase
      cont    = m1[2];
      oldSize = listQ.size();
      eff     = (cont && mIdx >= oldSize) ? 0 : mIdx;
      launch  = trig && !mBusy && (eff < oldSize);
      ent     = launch ? listQ[eff] : 8'h00;
      done    = mBusy && convDone;
      halfNow = sampQ.size() >= 16;
      extSet  = edgeM && m1[9];
      halfSet = halfNow && !mPrevHalf && m1[8];
      clr     = busWr && busAddr == 2'd2;
      pop     = busRd && busAddr == 2'd2 && sampQ.size() > 0;
      // channel list
      if (!m2[9]) begin
        listQ.delete(); mIdx = 0;
      end else begin
        if (launch) begin
          nxt = eff + 1;
          mIdx = (cont && nxt == oldSize) ? 0 : nxt;
        end
        if (busWr && busAddr == 2'd3 && oldSize < 16) listQ.push_back(busWdata[7:0]);
      end
      // sample FIFO
      if (pop) lastS = sampQ[0];
      if (!m2[10]) sampQ.delete();
      else begin
        if (pop) void'(sampQ.pop_front());
        if (done && sampQ.size() < 32) sampQ.push_back(convData ^ 12'h800);
      end
      // converter handshake
      mStart = launch;
      if (launch) begin mBusy = 1; mSel = ent; end
      else if (done) mBusy = 0;
      mPendExt  = (clr ? 1'b0 : mPendExt) | extSet;
      mPendHalf = (clr ? 1'b0 : mPendHalf) | halfSet;
      mPrevHalf = halfNow;
      mExtPrev  = extTrig;
      if (busWr && busAddr == 2'd0) m1 = busWdata;
      if (busWr && busAddr == 2'd1) m2 = busWdata;
    end
  end

  function automatic logic [15:0] predRd();
    logic [15:0] st;
    st = '0;
    st[9] = mPendExt; st[8] = mPendHalf;
    st[4] = sampQ.size() == 32; st[3] = sampQ.size() >= 16;
    st[2] = sampQ.size() == 0;  st[1] = listQ.size() == 16; st[0] = mBusy;
    case (busAddr)
      2'd1: return st;
      2'd2: return {4'h0, (sampQ.size() > 0) ? sampQ[0] : lastS};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] a, input logic w, input logic r, input logic [15:0] d,
                      input logic scan, input logic dn, input logic [11:0] cd);
    busAddr = a; busWr = w; busRd = r; busWdata = d;
    scanTick = scan; convDone = dn; convData = cd; extTrig = extLvl;
    #1;
    rdSample = busRdata;
    if (modelOn) begin
      chk(curReq, busRdata, predRd());
      chk(curReq, irq, {mBusy & 1'b0, m1[15] & (mPendExt | mPendHalf)});
      chk(curReq, {convStart, convDiff, convUnipolar, convGain, convChan}, {mStart, mSel});
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d); step(a, 1, 0, d, 0, 0, 0); endtask
  task automatic rdv(input logic [1:0] a, output logic [15:0] v); step(a, 0, 1, 0, 0, 0, 0); v = rdSample; endtask
  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic trig(); step(0, 0, 1, 0, 0, 0, 0); endtask
  task automatic done(input logic [11:0] cd); step(0, 0, 0, 0, 0, 1, cd); endtask

  function automatic logic [7:0] sel();
    return {convDiff, convUnipolar, convGain, convChan};
  endfunction

  bit finished = 0;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin : stim
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelOn = 1'b1;
    // R1 reset state
    curReq = "R1";
    rdv(1, v);
    chk("R1", v, 16'h0004);
    chk("R1", {irq, convStart}, 2'b00);
    // R2 address map reads
    curReq = "R2";
    rdv(3, v); chk("R2", v, 16'h0000);
    rdv(0, v); chk("R2", v, 16'h0000);
    // enable both stores, load three entries
    wr(1, 16'h0600);
    wr(3, 16'h0012); wr(3, 16'h006F); wr(3, 16'h00A3);
    curReq = "R4";
    wr(0, 16'h0001);
    trig();
    chk("R4", convStart, 1'b1);
    chk("R3", sel(), 8'h12);
    curReq = "R7";
    rdv(1, v); chk("R7", v[0], 1'b1);
    trig(); chk("R7", convStart, 1'b0);
    curReq = "R8";
    done(12'h123);
    rdv(2, v); chk("R8", v, 16'h0923);
    curReq = "R6";
    trig(); chk("R6", sel(), 8'h6F); chk("R3", {convDiff, convUnipolar, convGain, convChan}, {1'b0, 1'b1, 2'b10, 4'hF});
    done(12'h0FF);
    trig(); chk("R6", sel(), 8'hA3);
    done(12'h7FF);
    trig(); chk("R6", convStart, 1'b0);
    wr(0, 16'h0005);
    trig(); chk("R6", {convStart, sel()}, {1'b1, 8'h12});
    done(12'h001);
    curReq = "R4";
    wr(0, 16'h0004);
    trig(); chk("R4", convStart, 1'b0);
    curReq = "R5";
    wr(0, 16'h0006);
    step(0, 0, 0, 0, 1, 0, 0); chk("R5", {convStart, sel()}, {1'b1, 8'h6F});
    done(12'h200);
    wr(0, 16'h0007);
    extLvl = 1; idle(); chk("R5", convStart, 1'b1);
    done(12'h300);
    extLvl = 0; idle(); chk("R5", convStart, 1'b0);
    wr(0, 16'h000F);
    extLvl = 1; idle(); chk("R5", convStart, 1'b0);
    extLvl = 0; idle(); chk("R5", convStart, 1'b1);
    done(12'h400);
    // R9 flush
    curReq = "R9";
    wr(1, 16'h0200);
    idle();
    rdv(1, v); chk("R9", v[4:2], 3'b001);
    rdv(2, v); chk("R11", v, 16'h0923);
    wr(1, 16'h0000);
    idle();
    wr(3, 16'h0055);
    wr(1, 16'h0600);
    wr(0, 16'h0005);
    trig(); chk("R9", convStart, 1'b0);
    // list full, half-full interrupt
    curReq = "R11";
    for (int i = 0; i < 16; i++) wr(3, 16'(i));
    wr(3, 16'h00FF);
    rdv(1, v); chk("R10", v[1], 1'b1);
    wr(0, 16'h8105);
    curReq = "R12";
    for (int i = 0; i < 16; i++) begin
      trig();
      done(12'(i * 7));
    end
    idle(); idle();
    chk("R12", irq, 1'b1);
    rdv(1, v); chk("R10", {v[8], v[3]}, 2'b11);
    trig(); chk("R11", sel(), 8'h00);
    done(12'h0AA);
    curReq = "R13";
    wr(2, 16'h0000); chk("R13", irq, 1'b0);
    curReq = "R11";
    for (int i = 0; i < 15; i++) begin
      trig();
      done(12'(i + 100));
    end
    rdv(1, v); chk("R10", v[4], 1'b1);
    trig(); done(12'hABC);
    // R14 collision of pop and result
    curReq = "R14";
    trig();
    step(2, 0, 1, 0, 0, 1, 12'h456);
    rdv(1, v); chk("R14", v[4], 1'b1);
    for (int i = 0; i < 32; i++) rdv(2, v);
    chk("R14", v, 16'h0C56);
    rdv(2, v); chk("R11", v, 16'h0C56);
    // external interrupt and clear collision
    curReq = "R12";
    wr(0, 16'h8203);
    extLvl = 1; idle(); idle();
    chk("R12", irq, 1'b1);
    done(12'h010);
    curReq = "R13";
    wr(2, 16'h0000); chk("R13", irq, 1'b0);
    extLvl = 0; idle();
    extLvl = 1; wr(2, 16'h0000);
    chk("R13", irq, 1'b1);
    rdv(1, v); chk("R13", v[9], 1'b1);
    wr(2, 16'h0000);
    rdv(1, v); chk("R13", v[9], 1'b0);
    idle();
    finished = 1;
    summary();
  end
endmodule